// File: doc/BRIEF.md
# Integer ALU with Compare Flags

This block is the combinational arithmetic-logic unit of a small load-store processor core. It takes two operands and a 4-bit operation code and returns a result word together with three flags: zero, overflow and carry-out. A single adder serves addition, subtraction and both kinds of less-than comparison. For subtraction the adder sees every bit of the second operand inverted and a carry-in of one. The bitwise operations bypass the adder entirely, and a final select picks the path that the operation code names.

Each add and subtract exists in two forms. The trapping form reports signed overflow, and the non-trapping form always leaves the overflow flag clear. The signed comparison takes the sign of the difference corrected by the overflow condition, so it stays right when the subtraction wraps. The unsigned comparison uses the inverted carry-out of the subtraction. Decode the zero flag after a subtraction to test two operands for equality.

Top module: `int_alu`

## Requirements
- R1: Bitwise codes: 4'b0000 gives A AND B, 4'b0001 gives A OR B, 4'b1100 gives NOT(A OR B), 4'b1101 gives A XOR B.
- R2: Codes 4'b0010 (trapping add) and 4'b0011 (non-trapping add) give (A + B) mod 2^W, and the carry flag equals bit W of the full sum.
- R3: Codes 4'b0110 (trapping subtract) and 4'b0100 (non-trapping subtract) give (A - B) mod 2^W, and the carry flag is 1 exactly when A >= B as unsigned numbers (no borrow).
- R4: For code 4'b0010 the overflow flag is 1 exactly when A and B share a sign and the result's sign differs from it.
- R5: For code 4'b0110 the overflow flag is 1 exactly when A and B differ in sign and the result's sign differs from A's sign.
- R6: The overflow flag is 0 for every code other than 4'b0010 and 4'b0110.
- R7: Code 4'b0111 puts 1 in result bit 0 when A < B as two's complement numbers, including when A - B overflows; all other result bits are 0.
- R8: Code 4'b1000 puts 1 in result bit 0 when A < B as unsigned numbers; all other result bits are 0.
- R9: The zero flag is 1 exactly when every result bit is 0.
- R10: The carry flag is 0 for the bitwise codes and for unused codes; for codes 4'b0111 and 4'b1000 it is the carry-out of A - B.
- R11: Any unused code (4'b0101, 4'b1001, 4'b1010, 4'b1011, 4'b1110, 4'b1111) gives result 0.
- R12: The unit holds no state: every output is a function of the present inputs only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W | First operand |
| opb | input | W | Second operand |
| op_sel | input | 4 | Operation code |
| result | output | W | Selected result word |
| zero_flag | output | 1 | Result is all zeros |
| ovf_flag | output | 1 | Signed overflow of a trapping add or subtract |
| carry_flag | output | 1 | Adder carry-out for arithmetic and compare codes |

## Verification
Every result and flag is due in the same cycle as the operands and operation code that produce it, because no register lies between any input and any output. The bench applies each new input set just after a rising clock edge and compares all four outputs at the following falling edge, half a period later, when the logic has settled. A 4-bit copy of the unit is swept over every operand pair under every one of the sixteen codes, and the expected values are worked out with plain integer arithmetic. A full-width copy is then given sign-boundary cases, including all-ones against one.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [3:0]   op_sel,
  output logic [W-1:0] result,
  output logic         zero_flag,
  output logic         ovf_flag,
  output logic         carry_flag
);
  localparam logic [3:0] OP_AND  = 4'b0000;
  localparam logic [3:0] OP_OR   = 4'b0001;
  localparam logic [3:0] OP_ADD  = 4'b0010;
  localparam logic [3:0] OP_ADDU = 4'b0011;
  localparam logic [3:0] OP_SUBU = 4'b0100;
  localparam logic [3:0] OP_SUB  = 4'b0110;
  localparam logic [3:0] OP_SLT  = 4'b0111;
  localparam logic [3:0] OP_SLTU = 4'b1000;
  localparam logic [3:0] OP_NOR  = 4'b1100;
  localparam logic [3:0] OP_XOR  = 4'b1101;
  localparam int MSB = W - 1;

  logic         use_sub;
  logic [W-1:0] b_path;
  logic [W:0]   sum_full;
  logic         sgn_ovf;
  logic         lt_s, lt_u;

  assign use_sub  = (op_sel == OP_SUB) || (op_sel == OP_SUBU) ||
                    (op_sel == OP_SLT) || (op_sel == OP_SLTU);
  assign b_path   = use_sub ? ~opb : opb;
  assign sum_full = {1'b0, opa} + {1'b0, b_path} + {{W{1'b0}}, use_sub};
  assign sgn_ovf  = (opa[MSB] == b_path[MSB]) && (sum_full[MSB] != opa[MSB]);
  assign lt_s     = sum_full[MSB] ^ sgn_ovf;
  assign lt_u     = ~sum_full[W];

  always_comb begin
    result     = '0;
    ovf_flag   = 1'b0;
    carry_flag = 1'b0;
    unique case (op_sel)
      OP_AND:  result = opa & opb;
      OP_OR:   result = opa | opb;
      OP_NOR:  result = ~(opa | opb);
      OP_XOR:  result = opa ^ opb;
      OP_ADD, OP_SUB: begin
        result     = sum_full[MSB:0];
        carry_flag = sum_full[W];
        ovf_flag   = sgn_ovf;
      end
      OP_ADDU, OP_SUBU: begin
        result     = sum_full[MSB:0];
        carry_flag = sum_full[W];
      end
      OP_SLT: begin
        result     = {{(W-1){1'b0}}, lt_s};
        carry_flag = sum_full[W];
      end
      OP_SLTU: begin
        result     = {{(W-1){1'b0}}, lt_u};
        carry_flag = sum_full[W];
      end
      default: result = '0;
    endcase
    zero_flag = ~|result;

    AST_NO_OVERFLOW: assert (!(ovf_flag && op_sel != OP_ADD && op_sel != OP_SUB)); // R6
    AST_CMP_SHAPE: assert (!((op_sel == OP_SLT || op_sel == OP_SLTU) && result[MSB:1] != '0)); // R7
    AST_SLTU_ORDER: assert (!(op_sel == OP_SLTU && result[0] != (opa < opb))); // R8
    AST_SUBU_CARRY: assert (!(op_sel == OP_SUBU && carry_flag != (opa >= opb))); // R3
    AST_ADD_OVF_SIGN: assert (!(op_sel == OP_ADD && ovf_flag && opa[MSB] != opb[MSB])); // R4
    AST_LOGIC_NO_CARRY: assert (!(carry_flag && (op_sel == OP_AND || op_sel == OP_OR ||
                                 op_sel == OP_NOR || op_sel == OP_XOR))); // R10
    AST_UNUSED_ZERO: assert (!(!use_sub && op_sel != OP_ADD && op_sel != OP_ADDU &&
                              op_sel != OP_AND && op_sel != OP_OR && op_sel != OP_NOR &&
                              op_sel != OP_XOR && !zero_flag)); // R11
  end
endmodule

// File: tb/sim_int_alu.sv
module sim_int_alu;
  localparam int SW = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [SW-1:0] sa, sb, sres;
  logic [3:0]    sop;
  logic          sz, sv, sc;
  logic [31:0]   wa, wb, wres;
  logic [3:0]    wop;
  logic          wz, wv, wc;

  int_alu #(.W(SW)) u0 (.opa(sa), .opb(sb), .op_sel(sop), .result(sres),
                        .zero_flag(sz), .ovf_flag(sv), .carry_flag(sc));
  int_alu #(.W(32)) u1 (.opa(wa), .opb(wb), .op_sel(wop), .result(wres),
                        .zero_flag(wz), .ovf_flag(wv), .carry_flag(wc));

  task automatic chk(input string req, input longint act, input longint exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (op=%b a=%0h b=%0h)", req, what, act, exp, sop, sa, sb);
    end
  endtask

  function automatic longint sval(input longint v, input int w);
    return (v >= (longint'(1) << (w-1))) ? v - (longint'(1) << w) : v;
  endfunction

  task automatic expect_op(input int w, input longint a, input longint b, input int op,
                           output longint r, output longint v, output longint c);
    longint m = (longint'(1) << w) - 1;
    longint s_a = sval(a, w);
    longint s_b = sval(b, w);
    longint lo = -(longint'(1) << (w-1));
    longint hi = (longint'(1) << (w-1)) - 1;
    r = 0; v = 0; c = 0;
    case (op)
      0:  r = a & b;
      1:  r = a | b;
      12: r = ~(a | b) & m;
      13: r = a ^ b;
      2, 3: begin
        r = (a + b) & m; c = (a + b) >> w;
        if (op == 2) v = ((s_a + s_b) < lo || (s_a + s_b) > hi) ? 1 : 0;
      end
      6, 4: begin
        r = (a - b) & m; c = (a >= b) ? 1 : 0;
        if (op == 6) v = ((s_a - s_b) < lo || (s_a - s_b) > hi) ? 1 : 0;
      end
      7: begin r = (s_a < s_b) ? 1 : 0; c = (a >= b) ? 1 : 0; end
      8: begin r = (a < b) ? 1 : 0;     c = (a >= b) ? 1 : 0; end
      default: r = 0;
    endcase
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0, 1, 12, 13: return "R1";
      2, 3:         return "R2";
      4, 6:         return "R3";
      7:            return "R7";
      8:            return "R8";
      default:      return "R11";
    endcase
  endfunction

  task automatic wide(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op,
                      input string req);
    longint r, v, c;
    @(posedge clk); #1;
    wa = a; wb = b; wop = op;
    @(negedge clk);
    expect_op(32, longint'(a), longint'(b), int'(op), r, v, c);
    chk(req, longint'(wres), r, "wide result");
    chk("R6", longint'(wv), v, "wide overflow");
    chk("R10", longint'(wc), c, "wide carry");
    chk("R9", longint'(wz), (r == 0) ? 1 : 0, "wide zero");
  endtask

  initial begin
    sa = '0; sb = '0; sop = 4'd0; wa = '0; wb = '0; wop = 4'd0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12", longint'(sres), 0, "idle result");
    chk("R9", longint'(sz), 1, "idle zero");
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          longint r, v, c;
          @(posedge clk); #1;
          sa = a[SW-1:0]; sb = b[SW-1:0]; sop = op[3:0];
          @(negedge clk);
          expect_op(SW, a, b, op, r, v, c);
          chk(tag_of(op), longint'(sres), r, "result");
          chk((op == 2) ? "R4" : (op == 6) ? "R5" : "R6", longint'(sv), v, "overflow");
          chk((op == 4 || op == 6) ? "R3" : (op == 2 || op == 3) ? "R2" : "R10",
              longint'(sc), c, "carry");
          chk("R9", longint'(sz), (r == 0) ? 1 : 0, "zero");
        end
      end
    end
    wide(32'hFFFF_FFFF, 32'h0000_0001, 4'b0111, "R7");
    wide(32'hFFFF_FFFF, 32'h0000_0001, 4'b1000, "R8");
    wide(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010, "R4");
    wide(32'h7FFF_FFFF, 32'h0000_0001, 4'b0011, "R6");
    wide(32'h8000_0000, 32'h0000_0001, 4'b0110, "R5");
    wide(32'h8000_0000, 32'h0000_0001, 4'b0111, "R7");
    wide(32'h7FFF_FFFF, 32'h8000_0000, 4'b0111, "R7");
    wide(32'h1234_5678, 32'h1234_5678, 4'b0100, "R3");
    wide(32'hFFFF_FFFF, 32'h0000_0001, 4'b0011, "R2");
    wide(32'h0000_3C00, 32'h0000_0D00, 4'b0000, "R1");
    wide(32'hDEAD_BEEF, 32'h1234_5678, 4'b1111, "R11");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule